// File: doc/BRIEF.md
# Sleep and Wake Controller with Pulsed Indicator

This block decides when a powered device drops into a low-power state and what it does while there. Three synchronized logic inputs drive it: a sleep request, a wake request and an active-low ultra-low-power select. A falling edge on the wake input always brings the device back to normal operation. Sleep entry depends on a build-time choice. One variant enters on a single falling edge of the sleep input. The other variant enters only after the sleep input has stayed low for a long qualification time.

While asleep, the block drives two outputs that repeat on their own fixed cadences. The first is an indicator LED enable, on for one quarter of a 4 ms period. The second is a keep-alive load enable that holds up the line's power signature. In normal sleep this load runs at 75% duty. In ultra-low-power sleep it is on for about 84 ms and then off for about 228 ms. A prescaler turns the system clock into a millisecond tick, and all timing counts in those ticks. The prescaler and both cadences restart at sleep entry, so every pulse width comes out as an exact number of clock cycles.

Top module: `pd_sleep_ctrl`

## Requirements
- R1: After reset, sleep_o, ulp_o, led_o and keepalive_o are all low.
- R2: With QUALIFIED=0, a clock edge that samples sleep_i low, after the previous edge sampled it high, enters sleep at that edge. A low level held with no such transition does not enter sleep.
- R3: With QUALIFIED=1, sleep_o rises exactly HOLD_TICKS*TICK_DIV cycles after the edge that sampled the falling transition, provided sleep_i stays low throughout. If sleep_i returns high earlier, the entry is cancelled.
- R4: ulp_o is set at entry when ulp_sel_ni is low at the entry edge, and cleared otherwise. Later changes of ulp_sel_ni have no effect until the next entry.
- R5: A falling transition on wake_i while asleep returns to normal operation at that edge, with all four outputs low.
- R6: If the wake falling transition is sampled on the same edge that would enter sleep, the block stays awake.
- R7: While asleep, led_o is high during the first LED_ON_TICKS ticks of every LED_PERIOD_TICKS-tick period, counted from entry.
- R8: In ultra-low-power sleep, keepalive_o is high for KA_ULP_ON_TICKS ticks and then low for KA_ULP_OFF_TICKS ticks, repeating from entry.
- R9: In normal sleep, keepalive_o is high during the first KA_NORM_ON_TICKS ticks of every KA_NORM_PERIOD_TICKS-tick period, counted from entry.
- R10: While awake, led_o and keepalive_o are low. The tick prescaler and both cadences restart at every entry, so tick k after entry spans cycles k*TICK_DIV to (k+1)*TICK_DIV-1.
- R11: Sleep-input transitions while asleep are ignored. The cadences and the sleep mode continue undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep request; a falling transition starts entry |
| wake_i | input | 1 | Wake request; a falling transition leaves sleep |
| ulp_sel_ni | input | 1 | Low selects ultra-low-power sleep at entry |
| sleep_o | output | 1 | High in either sleep mode |
| ulp_o | output | 1 | High in ultra-low-power sleep |
| led_o | output | 1 | Indicator LED pulse enable |
| keepalive_o | output | 1 | Keep-alive load enable |

## Verification
The hardest conditions to reach from the ports are two. The first is a wake transition that lands on exactly the entry edge. The second is a qualification hold that is dropped one or more ticks before it completes. The bench forces the wake race by lowering both request inputs in the same cycle. It cancels the qualified entry at a randomly chosen cycle inside the hold window, then watches for a full window that no entry follows. During each sleep period it also toggles sleep_i and ulp_sel_ni partway through and checks every cycle against a computed cadence. This shows that mid-sleep activity neither restarts the counters nor changes the mode.

// File: rtl/pd_sleep_pkg.sv
package pd_sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ULP   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pd_tick_gen.sv
module pd_tick_gen #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pd_hold_qual.sv
module pd_hold_qual #(
  parameter int unsigned HOLD_TICKS = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fall_i,
  input  logic low_i,
  input  logic tick_i,
  output logic req_o
);
  localparam int unsigned W = $clog2(HOLD_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(HOLD_TICKS - 1);

  logic         armed_q;
  logic [W-1:0] cnt_q;

  assign req_o = en_i & armed_q & low_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fall_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!low_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pd_cadence.sv
module pd_cadence #(
  parameter int unsigned ON_TICKS     = 1,
  parameter int unsigned PERIOD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic on_o
);
  localparam int unsigned W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD_TICKS - 1);
  localparam logic [W:0]   ON_W = (W+1)'(ON_TICKS);

  logic [W-1:0] phase_q;

  assign on_o = ({1'b0, phase_q} < ON_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clr_i)   phase_q <= '0;
    else if (tick_i)  phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/pd_sleep_ctrl.sv
module pd_sleep_ctrl
  import pd_sleep_pkg::*;
#(
  parameter bit          QUALIFIED            = 1'b0,
  parameter int unsigned TICK_DIV             = 200000,
  parameter int unsigned HOLD_TICKS           = 6000,
  parameter int unsigned LED_ON_TICKS         = 1,
  parameter int unsigned LED_PERIOD_TICKS     = 4,
  parameter int unsigned KA_ULP_ON_TICKS      = 84,
  parameter int unsigned KA_ULP_OFF_TICKS     = 228,
  parameter int unsigned KA_NORM_ON_TICKS     = 3,
  parameter int unsigned KA_NORM_PERIOD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic wake_i,
  input  logic ulp_sel_ni,
  output logic sleep_o,
  output logic ulp_o,
  output logic led_o,
  output logic keepalive_o
);
  localparam int unsigned KA_ULP_PERIOD = KA_ULP_ON_TICKS + KA_ULP_OFF_TICKS;

  pwr_state_e state_q;
  logic sleep_q, wake_q;
  logic sleep_fall, wake_fall, awake;
  logic enter_req, enter, presc_clr, tick;
  logic led_on, ka_ulp_on, ka_norm_on;

  // inputs idle high; reset to 1 so no false edge at release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b1;
      wake_q  <= 1'b1;
    end else begin
      sleep_q <= sleep_i;
      wake_q  <= wake_i;
    end
  end

  assign sleep_fall = sleep_q & ~sleep_i;
  assign wake_fall  = wake_q & ~wake_i;
  assign awake      = (state_q == ST_AWAKE);
  assign enter      = awake & enter_req & ~wake_fall;
  assign presc_clr  = enter | (awake & sleep_fall);

  pd_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (presc_clr),
    .tick_o(tick)
  );

  generate
    if (QUALIFIED) begin : g_qual
      pd_hold_qual #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (awake),
        .fall_i(sleep_fall),
        .low_i (~sleep_i),
        .tick_i(tick),
        .req_o (enter_req)
      );
    end else begin : g_edge
      assign enter_req = sleep_fall;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
    end else if (enter) begin
      state_q <= ulp_sel_ni ? ST_SLEEP : ST_ULP;
    end else if (!awake && wake_fall) begin
      state_q <= ST_AWAKE;
    end
  end

  pd_cadence #(.ON_TICKS(LED_ON_TICKS), .PERIOD_TICKS(LED_PERIOD_TICKS)) i_led_cad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (enter),
    .tick_i(tick),
    .on_o  (led_on)
  );

  pd_cadence #(.ON_TICKS(KA_ULP_ON_TICKS), .PERIOD_TICKS(KA_ULP_PERIOD)) i_ka_ulp_cad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (enter),
    .tick_i(tick),
    .on_o  (ka_ulp_on)
  );

  pd_cadence #(.ON_TICKS(KA_NORM_ON_TICKS), .PERIOD_TICKS(KA_NORM_PERIOD_TICKS)) i_ka_norm_cad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (enter),
    .tick_i(tick),
    .on_o  (ka_norm_on)
  );

  assign sleep_o     = ~awake;
  assign ulp_o       = (state_q == ST_ULP);
  assign led_o       = ~awake & led_on;
  assign keepalive_o = ~awake & ((state_q == ST_ULP) ? ka_ulp_on : ka_norm_on);
endmodule

// File: rtl/pd_sleep_ctrl_chk.sv
module pd_sleep_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_i,
  input logic wake_i,
  input logic ulp_sel_ni,
  input logic sleep_o,
  input logic ulp_o,
  input logic led_o,
  input logic keepalive_o
);
  logic wake_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_d <= 1'b1;
    else         wake_d <= wake_i;
  end

  p_quiet_awake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_o |-> (!led_o && !keepalive_o));

  p_ulp_in_sleep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulp_o |-> sleep_o);

  p_ulp_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && $past(sleep_o)) |-> $stable(ulp_o));

  p_ulp_pick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> (ulp_o == $past(!ulp_sel_ni)));

  p_entry_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(!sleep_i));

  p_wake_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_d && !wake_i && sleep_o) |=> !sleep_o);

  p_wake_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_d && !wake_i && !sleep_o) |=> !sleep_o);
endmodule

bind pd_sleep_ctrl pd_sleep_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_i    (sleep_i),
  .wake_i     (wake_i),
  .ulp_sel_ni (ulp_sel_ni),
  .sleep_o    (sleep_o),
  .ulp_o      (ulp_o),
  .led_o      (led_o),
  .keepalive_o(keepalive_o)
);

// File: tb/test_pd_sleep_ctrl.sv
`timescale 1ns/1ps
module test_pd_sleep_ctrl;
  localparam int DIV  = 4;
  localparam int H    = 10;
  localparam int LON  = 1;
  localparam int LP   = 4;
  localparam int KON  = 5;
  localparam int KOFF = 12;
  localparam int NON  = 3;
  localparam int NP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n = 1'b1, wake_n = 1'b1, ulp_n = 1'b1;
  logic e_sleep, e_ulp, e_led, e_ka;
  logic q_sleep, q_ulp, q_led, q_ka;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pd_sleep_ctrl #(
    .QUALIFIED(1'b0), .TICK_DIV(DIV), .HOLD_TICKS(H),
    .LED_ON_TICKS(LON), .LED_PERIOD_TICKS(LP),
    .KA_ULP_ON_TICKS(KON), .KA_ULP_OFF_TICKS(KOFF),
    .KA_NORM_ON_TICKS(NON), .KA_NORM_PERIOD_TICKS(NP)
  ) i_pd_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep_n), .wake_i(wake_n),
    .ulp_sel_ni(ulp_n), .sleep_o(e_sleep), .ulp_o(e_ulp),
    .led_o(e_led), .keepalive_o(e_ka)
  );

  pd_sleep_ctrl #(
    .QUALIFIED(1'b1), .TICK_DIV(DIV), .HOLD_TICKS(H),
    .LED_ON_TICKS(LON), .LED_PERIOD_TICKS(LP),
    .KA_ULP_ON_TICKS(KON), .KA_ULP_OFF_TICKS(KOFF),
    .KA_NORM_ON_TICKS(NON), .KA_NORM_PERIOD_TICKS(NP)
  ) i_pd_sleep_ctrl_q (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep_n), .wake_i(wake_n),
    .ulp_sel_ni(ulp_n), .sleep_o(q_sleep), .ulp_o(q_ulp),
    .led_o(q_led), .keepalive_o(q_ka)
  );

  function automatic logic led_exp(int k);
    return ((k / DIV) % LP) < LON;
  endfunction

  function automatic logic ka_exp(int k, bit ulp);
    if (ulp) return ((k / DIV) % (KON + KOFF)) < KON;
    return ((k / DIV) % NP) < NON;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // caller stands just after the entry edge
  task automatic run_wave(bit q, bit ulp, int n);
    for (int k = 0; k < n; k++) begin
      string tag;
      @(negedge clk);
      tag = (k > 9) ? "R11" : (q ? "R3" : "R2");
      chk({tag, " sleep_o"}, q ? q_sleep : e_sleep, 1'b1);
      chk({(k > 11) ? "R11" : "R4", " ulp_o"}, q ? q_ulp : e_ulp, ulp);
      chk({(k > 9) ? "R11" : "R7", " led_o"}, q ? q_led : e_led, led_exp(k));
      chk({ulp ? "R8" : "R9", " keepalive_o"}, q ? q_ka : e_ka, ka_exp(k, ulp));
      if (k == 7)  sleep_n = 1'b1;
      if (k == 9)  sleep_n = 1'b0;
      if (k == 11) ulp_n = ~ulp_n;
    end
  endtask

  task automatic do_wake(bit q);
    @(negedge clk);
    wake_n = 1'b0;
    @(negedge clk);
    chk("R5 sleep_o after wake", q ? q_sleep : e_sleep, 1'b0);
    chk("R5 ulp_o after wake", q ? q_ulp : e_ulp, 1'b0);
    chk("R10 led_o after wake", q ? q_led : e_led, 1'b0);
    chk("R10 keepalive_o after wake", q ? q_ka : e_ka, 1'b0);
    wake_n  = 1'b1;
    sleep_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic edge_run(bit ulp, int n);
    @(negedge clk);
    ulp_n   = ~ulp;
    sleep_n = 1'b0;
    @(posedge clk);
    run_wave(1'b0, ulp, n);
    do_wake(1'b0);
  endtask

  task automatic qual_run(bit ulp, int n);
    @(negedge clk);
    ulp_n   = ~ulp;
    sleep_n = 1'b0;
    @(posedge clk);
    repeat (H * DIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 not yet entered", q_sleep, 1'b0);
    @(posedge clk);
    run_wave(1'b1, ulp, n);
    do_wake(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk("R1 sleep_o reset", e_sleep, 1'b0);
    chk("R1 led_o reset", e_led, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sleep_o", e_sleep | q_sleep, 1'b0);
    chk("R1 ulp_o", e_ulp | q_ulp, 1'b0);
    chk("R1 led_o", e_led | q_led, 1'b0);
    chk("R1 keepalive_o", e_ka | q_ka, 1'b0);

    // wake and sleep fall together
    sleep_n = 1'b0;
    wake_n  = 1'b0;
    @(negedge clk);
    chk("R6 wake wins", e_sleep, 1'b0);
    wake_n = 1'b1;
    // low level held with no new fall
    repeat (5) begin
      @(negedge clk);
      chk("R2 level alone", e_sleep, 1'b0);
    end
    sleep_n = 1'b1;
    repeat (3) @(negedge clk);

    edge_run(1'b0, 80);
    edge_run(1'b1, 100);

    for (int i = 0; i < 4; i++) begin
      edge_run(1'($urandom_range(0, 1)), int'($urandom_range(20, 100)));
    end

    // qualified cancel at random point in the hold window
    for (int i = 0; i < 3; i++) begin
      int m;
      m = int'($urandom_range(2, H * DIV - 2));
      @(negedge clk);
      sleep_n = 1'b0;
      for (int c = 0; c < m; c++) begin
        @(negedge clk);
        chk("R3 hold in progress", q_sleep, 1'b0);
      end
      sleep_n = 1'b1;
      for (int c = 0; c < H * DIV + 4; c++) begin
        @(negedge clk);
        chk("R3 cancelled", q_sleep, 1'b0);
      end
      do_wake(1'b0);
    end

    qual_run(1'b1, 90);
    qual_run(1'b0, 40);

    report();
    $finish;
  end
endmodule